// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst SRAM. Its data word is 36 bits wide and is split into four 9-bit lanes. Address, write data, chip selects and write controls are all sampled on the rising clock edge. Two address strobes can open an access. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls.

Once an address has been captured, a 2-bit beat counter supplies the following addresses of the burst. The counter steps only while the step input is held low. A mode input picks the beat order: linear wrap-around, or interleaved (start offset XOR count). Read data leaves through an output register, so a four-beat read follows a 3-1-1-1 pattern. An asynchronous output enable gates the valid flag. The bidirectional data bus is split into `wdata`, `rdata` and `rdata_vld`, so the model needs no tri-state logic.

Top module: `burst_sram`

## Requirements
- R1: After reset, `rdata_vld` is low and no burst is open, so holding `step_n` low produces no read data.
- R2: An address is taken from `addr` only on a strobe cycle. A processor strobe is ignored while `sel_a_n` is high. While a burst is open, changes on `addr` have no effect.
- R3: The chip is selected when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A controller strobe is always evaluated, even when `sel_a_n` is high. A strobe cycle that is not selected closes the burst. `rdata_vld` is then low after the second rising edge that follows it.
- R4: With `burst_ilv`=0, the beat address low bits are (start + count) mod 4.
- R5: With `burst_ilv`=1, the beat address low bits are start XOR count. For example, start 1 gives 1,0,3,2.
- R6: Read data for a beat sampled at edge E is valid after edge E+1. Later beats follow on every clock.
- R7: With `wr_all_n`=0 on a write cycle, all four lanes are written.
- R8: With `wr_all_n`=1 and `wr_lane_en_n`=0, bit i of `wr_lane_n` (active low) writes bits [9i+8:9i]. With `wr_lane_en_n`=1, no lane is written.
- R9: A processor-strobe cycle is a read, and write controls on that cycle are ignored. A following step cycle with write controls writes the next beat address.
- R10: `out_en_n`=1 forces `rdata_vld` low at once, without waiting for a clock edge.
- R11: A cycle with no strobe and `step_n`=1 keeps the current beat address and reads it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Advance the burst counter, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| burst_ilv | input | 1 | 1: interleaved order, 0: linear order |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enable per-lane writes, active low |
| wr_lane_n | input | 4 | Per-lane write selects, active low |
| wdata | input | 36 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Registered read data |
| rdata_vld | output | 1 | Read data valid and output driven |

## Verification
The assertions check four things on every cycle: output enable gating, the two-edge fall of the valid flag after a deselect, the two-edge read latency after a selected processor strobe, and the absence of read data after a controller write. Only the bench scenarios can show data correctness. These cover both beat orders from every start offset, lane-masked writes against a reference array, a processor strobe carrying write controls, and address hold while a burst is suspended.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW    = 10,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                strb_cpu_n,
  input  logic                strb_ctl_n,
  input  logic                step_n,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                burst_ilv,
  input  logic                wr_all_n,
  input  logic                wr_lane_en_n,
  input  logic [LANES-1:0]    wr_lane_n,
  input  logic [LANES*LW-1:0] wdata,
  input  logic                out_en_n,
  output logic [LANES*LW-1:0] rdata,
  output logic                rdata_vld
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    base_q, raddr_q, nxt_base, cur_addr;
  logic [1:0]       cnt_q, nxt_cnt, low;
  logic             act_q, nxt_act, rd_q, vld_q;
  logic [DW-1:0]    dout_q;
  logic             cpu_go, ctl_go, go, csel, do_wr, do_rd;
  logic [LANES-1:0] lanes;

  assign cpu_go   = !strb_cpu_n && !sel_a_n;
  assign ctl_go   = !strb_ctl_n && !cpu_go;
  assign go       = cpu_go || ctl_go;
  assign csel     = !sel_a_n && sel_b && !sel_c_n;

  assign nxt_base = go ? addr : base_q;
  assign nxt_cnt  = go ? 2'd0 : (!step_n ? cnt_q + 2'd1 : cnt_q);
  assign nxt_act  = go ? csel : act_q;
  assign low      = burst_ilv ? (nxt_base[1:0] ^ nxt_cnt) : (nxt_base[1:0] + nxt_cnt);
  assign cur_addr = {nxt_base[AW-1:2], low};

  assign lanes    = !wr_all_n ? '1 : (!wr_lane_en_n ? ~wr_lane_n : '0);
  assign do_wr    = rst_n && nxt_act && !cpu_go && (|lanes);
  assign do_rd    = nxt_act && !do_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cnt_q   <= 2'd0;
      base_q  <= '0;
      rd_q    <= 1'b0;
      raddr_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      act_q   <= nxt_act;
      cnt_q   <= nxt_cnt;
      base_q  <= nxt_base;
      rd_q    <= do_rd;
      raddr_q <= cur_addr;
      vld_q   <= rd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr)
      for (int i = 0; i < LANES; i++)
        if (lanes[i]) mem[cur_addr][i*LW +: LW] <= wdata[i*LW +: LW];
  end

  always_ff @(posedge clk) dout_q <= mem[raddr_q];

  assign rdata     = dout_q;
  assign rdata_vld = vld_q && !out_en_n;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic strb_cpu_n,
  input logic strb_ctl_n,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n,
  input logic wr_all_n,
  input logic out_en_n,
  input logic rdata_vld
);
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_vld);

  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strb_ctl_n || (!strb_cpu_n && !sel_a_n)) && !sel_b) |=> ##1 !rdata_vld);

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !sel_a_n && sel_b && !sel_c_n) |=> ##1 (rdata_vld || out_en_n));

  assert_write_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_cpu_n && !strb_ctl_n && !sel_a_n && sel_b && !sel_c_n && !wr_all_n)
      |=> ##1 !rdata_vld);
endmodule

bind burst_sram burst_sram_chk u_chk (.*);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 10;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic strb_cpu_n, strb_ctl_n, step_n, sel_a_n, sel_b, sel_c_n, burst_ilv;
  logic wr_all_n, wr_lane_en_n, out_en_n;
  logic [3:0] wr_lane_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_vld;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  // {interleaved, start[1:0], beat0..beat3 low bits}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 8'b00_01_10_11}, {1'b0, 2'd1, 8'b01_10_11_00},
    {1'b0, 2'd2, 8'b10_11_00_01}, {1'b0, 2'd3, 8'b11_00_01_10},
    {1'b1, 2'd0, 8'b00_01_10_11}, {1'b1, 2'd1, 8'b01_00_11_10},
    {1'b1, 2'd2, 8'b10_11_00_01}, {1'b1, 2'd3, 8'b11_10_01_00}
  };

  always #4 clk = ~clk;

  burst_sram #(.AW(AW)) i_burst_sram (.*);

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle_in;
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_all_n = 1'b1; wr_lane_en_n = 1'b1; wr_lane_n = 4'hF;
  endtask

  task automatic write1(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic gwn, input logic ben, input logic [3:0] bwn);
    logic [3:0] m;
    idle_in();
    addr = a; wdata = d; strb_ctl_n = 1'b0;
    wr_all_n = gwn; wr_lane_en_n = ben; wr_lane_n = bwn;
    m = !gwn ? 4'hF : (!ben ? ~bwn : 4'h0);
    for (int i = 0; i < 4; i++)
      if (m[i]) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
    tick();
    idle_in();
  endtask

  task automatic read1(input logic [AW-1:0] a, input string tag);
    idle_in();
    addr = a; strb_cpu_n = 1'b0;
    tick();
    idle_in();
    tick();
    chk(rdata_vld === 1'b1 && rdata === ref_mem[a], tag, rdata, ref_mem[a]);
  endtask

  initial begin
    #(8 * 50000);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle_in(); out_en_n = 1'b0; burst_ilv = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    chk(rdata_vld === 1'b0, "R1 reset valid", {35'd0, rdata_vld}, '0);
    step_n = 1'b0;
    tick(); tick();
    chk(rdata_vld === 1'b0, "R1 no burst after reset", {35'd0, rdata_vld}, '0);
    idle_in();

    // R7 fill with global writes
    for (int a = 'h40; a < 'h44; a++)
      write1(AW'(a), 36'(a) * 36'h0_0100_4011 + 36'h123, 1'b0, 1'b1, 4'hF);
    read1(AW'('h42), "R7 global write");

    // R4 R5 R6 vector table
    foreach (VEC[v]) begin
      logic [7:0] ord;
      ord = VEC[v][7:0];
      idle_in();
      burst_ilv = VEC[v][10];
      addr = AW'('h40) | AW'(VEC[v][9:8]);
      strb_cpu_n = 1'b0;
      tick();
      for (int b = 1; b <= 4; b++) begin
        logic [AW-1:0] ea;
        idle_in();
        if (b < 4) step_n = 1'b0;
        tick();
        ea = AW'('h40) | AW'(ord[7 - 2*(b-1) -: 2]);
        chk(rdata_vld === 1'b1 && rdata === ref_mem[ea],
            VEC[v][10] ? "R5 interleaved beat" : "R4 linear beat", rdata, ref_mem[ea]);
      end
    end
    burst_ilv = 1'b0;

    // R8 lane writes
    write1(AW'('h50), '1, 1'b0, 1'b1, 4'hF);
    write1(AW'('h50), '0, 1'b1, 1'b0, 4'b1110);
    read1(AW'('h50), "R8 single lane");
    write1(AW'('h51), '1, 1'b0, 1'b1, 4'hF);
    write1(AW'('h51), 36'h0_2468_ACE1, 1'b1, 1'b0, 4'b0110);
    read1(AW'('h51), "R8 two lanes");
    write1(AW'('h52), 36'h5_5555_5555, 1'b1, 1'b0, 4'b0000);
    read1(AW'('h52), "R8 four lanes");
    write1(AW'('h52), 36'h0_0000_0000, 1'b1, 1'b1, 4'b0000);
    read1(AW'('h52), "R8 lane enable off");

    // R9 processor strobe ignores write controls, later step writes
    write1(AW'('h60), 36'h1_1111_1111, 1'b0, 1'b1, 4'hF);
    write1(AW'('h61), 36'h2_2222_2222, 1'b0, 1'b1, 4'hF);
    idle_in();
    addr = AW'('h60); strb_cpu_n = 1'b0; wr_all_n = 1'b0; wdata = 36'hB_AD00_0BAD;
    tick();
    idle_in();
    step_n = 1'b0; wr_all_n = 1'b0; wdata = 36'h7_0F0F_0F0F;
    ref_mem[AW'('h61)] = 36'h7_0F0F_0F0F;
    tick();
    idle_in();
    read1(AW'('h60), "R9 strobe cycle not written");
    read1(AW'('h61), "R9 step cycle written");

    // R2 R11 address hold during suspended burst
    read1(AW'('h42), "R11 start");
    addr = AW'('h7F);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(rdata_vld === 1'b1 && rdata === ref_mem[AW'('h42)], "R2 R11 address held", rdata, ref_mem[AW'('h42)]);
    end

    // R10 asynchronous output enable
    out_en_n = 1'b1; #1;
    chk(rdata_vld === 1'b0, "R10 disable immediate", {35'd0, rdata_vld}, '0);
    out_en_n = 1'b0; #1;
    chk(rdata_vld === 1'b1, "R10 enable immediate", {35'd0, rdata_vld}, 36'd1);

    // R3 single-cycle deselect
    idle_in();
    strb_ctl_n = 1'b0; sel_b = 1'b0;
    tick();
    chk(rdata_vld === 1'b1, "R3 valid one edge after deselect", {35'd0, rdata_vld}, 36'd1);
    idle_in();
    tick();
    chk(rdata_vld === 1'b0, "R3 off two edges after deselect", {35'd0, rdata_vld}, '0);

    // R2 ignored processor strobe
    addr = AW'('h41); strb_cpu_n = 1'b0; sel_a_n = 1'b1;
    tick();
    idle_in();
    tick(); tick();
    chk(rdata_vld === 1'b0, "R2 processor strobe ignored", {35'd0, rdata_vld}, '0);

    // R3 controller strobe evaluated even with sel_a_n high
    read1(AW'('h43), "R3 reopen");
    strb_ctl_n = 1'b0; sel_a_n = 1'b1;
    tick();
    idle_in();
    tick();
    chk(rdata_vld === 1'b0, "R3 controller deselect via sel_a_n", {35'd0, rdata_vld}, '0);
    read1(AW'('h40), "R3 reopen 2");
    strb_ctl_n = 1'b0; sel_c_n = 1'b1;
    tick();
    idle_in();
    tick();
    chk(rdata_vld === 1'b0, "R3 deselect via sel_c_n", {35'd0, rdata_vld}, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule